// File: doc/BRIEF.md
# Instruction exception entry sequencer

This block sits beside a simple 32-bit CPU pipeline and takes over when the instruction being issued raises an exception of its own. It handles three causes: a software trap that carries an 8-bit vector number, an undefined opcode that follows a delayed branch or another PC-changing instruction, and an undefined opcode found anywhere else. Each cause has its own vector number. The two undefined-opcode causes use fixed numbers, and the trap uses the number carried in the instruction.

When a cause is accepted, the block stalls the pipeline and runs the entry sequence through a single-request memory port. It pushes the status word and then the return address onto a downward-growing stack. It then reads the handler address from a vector table. The final step is a one-cycle redirect of the fetch PC, issued together with the lowered stack pointer. The redirect is not delayed, so no instruction after the faulting one executes first. Every memory request is held stable until the memory returns ready.

Top module: `exc_entry_seq`

## Requirements
- R1: An accepted descriptor is classified as follows. An undefined opcode with the slot flag set uses vector 6. An undefined opcode with the slot flag clear uses vector 4. A trap with no undefined flag uses its own 8-bit vector number. When both flags are set, the undefined flag wins.
- R2: `busy` is high in the cycle a cause is accepted and stays high through the redirect cycle. Descriptors presented while the block is busy are ignored and do not change the vector being used.
- R3: The first memory request is a write (`mem_we`=1) of the captured status word to the address stack pointer minus 4.
- R4: The second memory request is a write of the return address to the address stack pointer minus 8. For a trap the return address is the trap's PC plus 2. For either undefined-opcode cause it is the PC of the faulting instruction.
- R5: The third memory request is a read (`mem_we`=0) at vector base plus 4 times the vector number.
- R6: A request with `mem_ready` low is held with unchanged address, data and direction in the following cycle.
- R7: The cycle after the read handshake, `redirect_valid` pulses for exactly one cycle. In that cycle `redirect_pc` equals the word that was read and `new_sp` equals the stack pointer minus 8.
- R8: After reset the block is idle: `busy`, `mem_req` and `redirect_valid` are low.
- R9: A valid descriptor with neither the undefined flag nor the trap flag set starts no sequence.
- R10: `mem_req` and `redirect_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_valid | input | 1 | Descriptor valid this cycle |
| instr_undef | input | 1 | Opcode is undefined |
| instr_trap | input | 1 | Opcode is a software trap |
| instr_in_slot | input | 1 | Instruction follows a delayed branch or a PC-changing instruction |
| trap_vec | input | 8 | Vector number carried by the trap |
| cur_pc | input | 32 | Address of the instruction |
| cur_sr | input | 32 | Current status word |
| cur_sp | input | 32 | Current stack pointer |
| vec_base | input | 32 | Vector table base address |
| busy | output | 1 | Pipeline stall while the sequence runs |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts or completes the request |
| mem_rdata | input | 32 | Read data, valid while `mem_ready` is high on a read |
| redirect_valid | output | 1 | One-cycle fetch redirect |
| redirect_pc | output | 32 | Handler address |
| new_sp | output | 32 | Stack pointer after both pushes, valid with the redirect |

## Verification
`busy` is combinational and rises in the same cycle the descriptor is presented. The first request appears one clock later, because one state register lies between the descriptor and the memory port. Each later request appears one clock after the handshake of the one before it, and the redirect appears one clock after the read handshake and lasts one cycle. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so each check lands in the cycle given by this register count. Wait states of zero, one and three cycles stretch the requests, and stability is checked in every stalled cycle.

// File: rtl/exc_pkg.sv
// Shared types for the exception entry sequencer.
package exc_pkg;

    // Sequencer steps, in the order they run.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_SR,
        ST_PUSH_PC,
        ST_VEC_RD,
        ST_REDIRECT
    } seq_state_t;

    // Cause of the exception being entered.
    typedef enum logic [1:0] {
        CAUSE_NONE,
        CAUSE_TRAP,
        CAUSE_SLOT_ILL,
        CAUSE_GEN_ILL
    } exc_cause_t;

endpackage

// File: rtl/exc_classify.sv
// Classifies an instruction descriptor into an exception cause, a vector
// number and a return address.
// Assumes: undefined wins over trap; illegal causes return to the faulting
// instruction, and traps return to the next instruction.
module exc_classify
    import exc_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int VEC_W       = 8,
    parameter int INSTR_BYTES = 2,
    parameter int SLOT_VEC    = 6,
    parameter int GEN_VEC     = 4
) (
    input  logic             valid,
    input  logic             undef,
    input  logic             trap,
    input  logic             in_slot,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic [XLEN-1:0]  pc,
    output logic             hit,
    output exc_cause_t       cause,
    output logic [VEC_W-1:0] vec_num,
    output logic [XLEN-1:0]  ret_pc
);

    // Pick the cause and vector by priority.
    always_comb begin
        hit     = valid && (undef || trap);
        cause   = CAUSE_NONE;
        vec_num = '0;
        if (valid && undef) begin
            cause   = in_slot ? CAUSE_SLOT_ILL : CAUSE_GEN_ILL;
            vec_num = in_slot ? VEC_W'(SLOT_VEC) : VEC_W'(GEN_VEC);
        end else if (valid && trap) begin
            cause   = CAUSE_TRAP;
            vec_num = trap_vec;
        end
    end

    // Return address depends on the cause.
    always_comb begin
        ret_pc = (cause == CAUSE_TRAP) ? pc + XLEN'(INSTR_BYTES) : pc;
    end

endmodule

// File: rtl/exc_addr_gen.sv
// Computes the two stack slots, the final stack pointer and the vector
// table entry address.
// Assumes: a full-descending stack with word-sized pushes.
module exc_addr_gen #(
    parameter int XLEN       = 32,
    parameter int VEC_W      = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic [XLEN-1:0]  sp,
    input  logic [XLEN-1:0]  base,
    input  logic [VEC_W-1:0] vec_num,
    output logic [XLEN-1:0]  sr_slot,
    output logic [XLEN-1:0]  pc_slot,
    output logic [XLEN-1:0]  vec_addr
);

    localparam int SHIFT = $clog2(WORD_BYTES);

    // Each push pre-decrements by one word.
    always_comb begin
        sr_slot  = sp - XLEN'(WORD_BYTES);
        pc_slot  = sp - XLEN'(2 * WORD_BYTES);
        vec_addr = base + (XLEN'(vec_num) << SHIFT);
    end

endmodule

// File: rtl/exc_seq_fsm.sv
// Runs the entry steps: push status, push return address, read the vector,
// then redirect. Captures all operands when a cause is accepted.
// Assumes: the memory port completes a request in the cycle ready is seen.
module exc_seq_fsm
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hit,
    input  logic [XLEN-1:0] sr_in,
    input  logic [XLEN-1:0] ret_pc_in,
    input  logic [XLEN-1:0] sr_slot_in,
    input  logic [XLEN-1:0] pc_slot_in,
    input  logic [XLEN-1:0] vec_addr_in,
    input  logic            mem_ready,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc,
    output logic [XLEN-1:0] new_sp
);

    seq_state_t      state;
    logic [XLEN-1:0] sr_q;
    logic [XLEN-1:0] ret_q;
    logic [XLEN-1:0] sr_slot_q;
    logic [XLEN-1:0] pc_slot_q;
    logic [XLEN-1:0] vec_addr_q;
    logic [XLEN-1:0] handler_q;

    // Step the sequence and capture operands and the handler word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            sr_q       <= '0;
            ret_q      <= '0;
            sr_slot_q  <= '0;
            pc_slot_q  <= '0;
            vec_addr_q <= '0;
            handler_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (hit) begin
                        state      <= ST_PUSH_SR;
                        sr_q       <= sr_in;
                        ret_q      <= ret_pc_in;
                        sr_slot_q  <= sr_slot_in;
                        pc_slot_q  <= pc_slot_in;
                        vec_addr_q <= vec_addr_in;
                    end
                end
                ST_PUSH_SR: if (mem_ready) state <= ST_PUSH_PC;
                ST_PUSH_PC: if (mem_ready) state <= ST_VEC_RD;
                ST_VEC_RD: begin
                    if (mem_ready) begin
                        handler_q <= mem_rdata;
                        state     <= ST_REDIRECT;
                    end
                end
                ST_REDIRECT: state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port from the current step.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sr_slot_q;
                mem_wdata = sr_q;
            end
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pc_slot_q;
                mem_wdata = ret_q;
            end
            ST_VEC_RD: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr_q;
            end
            default: ;
        endcase
    end

    // Stall, redirect pulse and final stack pointer.
    always_comb begin
        busy           = (state != ST_IDLE) || hit;
        redirect_valid = (state == ST_REDIRECT);
        redirect_pc    = handler_q;
        new_sp         = pc_slot_q;
    end

endmodule

// File: rtl/exc_entry_seq.sv
// Top of the instruction exception entry sequencer. Classifies the
// descriptor, forms the addresses and runs the entry steps.
// Assumes: descriptors are ignored while a sequence runs.
module exc_entry_seq #(
    parameter int XLEN        = 32,
    parameter int VEC_W       = 8,
    parameter int WORD_BYTES  = 4,
    parameter int INSTR_BYTES = 2,
    parameter int SLOT_VEC    = 6,
    parameter int GEN_VEC     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid,
    input  logic             instr_undef,
    input  logic             instr_trap,
    input  logic             instr_in_slot,
    input  logic [VEC_W-1:0] trap_vec,
    input  logic [XLEN-1:0]  cur_pc,
    input  logic [XLEN-1:0]  cur_sr,
    input  logic [XLEN-1:0]  cur_sp,
    input  logic [XLEN-1:0]  vec_base,
    output logic             busy,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic             mem_ready,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             redirect_valid,
    output logic [XLEN-1:0]  redirect_pc,
    output logic [XLEN-1:0]  new_sp
);

    import exc_pkg::*;

    logic             hit;
    exc_cause_t       cause;
    logic [VEC_W-1:0] vec_num;
    logic [XLEN-1:0]  ret_pc;
    logic [XLEN-1:0]  sr_slot;
    logic [XLEN-1:0]  pc_slot;
    logic [XLEN-1:0]  vec_addr;
    logic             cause_unused;

    // The cause is kept for future use by the pipeline; fold it here.
    always_comb cause_unused = ^cause;

    exc_classify #(
        .XLEN(XLEN), .VEC_W(VEC_W), .INSTR_BYTES(INSTR_BYTES),
        .SLOT_VEC(SLOT_VEC), .GEN_VEC(GEN_VEC)
    ) u_classify (
        .valid   (instr_valid),
        .undef   (instr_undef),
        .trap    (instr_trap),
        .in_slot (instr_in_slot),
        .trap_vec(trap_vec),
        .pc      (cur_pc),
        .hit     (hit),
        .cause   (cause),
        .vec_num (vec_num),
        .ret_pc  (ret_pc)
    );

    exc_addr_gen #(
        .XLEN(XLEN), .VEC_W(VEC_W), .WORD_BYTES(WORD_BYTES)
    ) u_addr (
        .sp      (cur_sp),
        .base    (vec_base),
        .vec_num (vec_num),
        .sr_slot (sr_slot),
        .pc_slot (pc_slot),
        .vec_addr(vec_addr)
    );

    exc_seq_fsm #(.XLEN(XLEN)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .hit           (hit),
        .sr_in         (cur_sr),
        .ret_pc_in     (ret_pc),
        .sr_slot_in    (sr_slot),
        .pc_slot_in    (pc_slot),
        .vec_addr_in   (vec_addr),
        .mem_ready     (mem_ready),
        .mem_rdata     (mem_rdata),
        .busy          (busy),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .redirect_valid(redirect_valid),
        .redirect_pc   (redirect_pc),
        .new_sp        (new_sp)
    );

endmodule

// File: rtl/exc_entry_chk.sv
// Protocol checks on the sequencer ports, bound to the top module.
module exc_entry_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_ready,
    input logic            redirect_valid
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R6

    AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |=> !redirect_valid); // R7

    AST_REDIRECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, redirect_valid})); // R10

    AST_STALL_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req || redirect_valid |-> busy); // R2

    AST_READ_BEFORE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(redirect_valid) |-> $past(mem_req && !mem_we && mem_ready)); // R7

endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN)) u_exc_entry_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ready     (mem_ready),
    .redirect_valid(redirect_valid)
);

// File: tb/test_exc_entry_seq.sv
module test_exc_entry_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_valid, instr_undef, instr_trap, instr_in_slot;
    logic [7:0]  trap_vec;
    logic [31:0] cur_pc, cur_sr, cur_sp, vec_base;
    logic        busy, mem_req, mem_we, mem_ready, redirect_valid;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, redirect_pc, new_sp;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    exc_entry_seq i_exc_entry_seq (
        .clk(clk), .rst_n(rst_n),
        .instr_valid(instr_valid), .instr_undef(instr_undef),
        .instr_trap(instr_trap), .instr_in_slot(instr_in_slot),
        .trap_vec(trap_vec), .cur_pc(cur_pc), .cur_sr(cur_sr),
        .cur_sp(cur_sp), .vec_base(vec_base),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
        .new_sp(new_sp)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_desc();
        instr_valid = 0; instr_undef = 0; instr_trap = 0; instr_in_slot = 0;
        trap_vec = 8'h00;
    endtask

    // Serve one request: check it, hold it for waits cycles, then complete it.
    task automatic serve(input string req, input logic we, input logic [31:0] addr,
                         input logic [31:0] wdata, input int waits, input logic [31:0] rdata);
        check({req, " req"}, {31'b0, mem_req}, 1);
        check({req, " dir"}, {31'b0, mem_we}, {31'b0, we});
        check({req, " addr"}, mem_addr, addr);
        if (we) check({req, " data"}, mem_wdata, wdata);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            check("R6 held req", {31'b0, mem_req}, 1);
            check("R6 held addr", mem_addr, addr);
            if (we) check("R6 held data", mem_wdata, wdata);
        end
        mem_ready = 1; mem_rdata = rdata;
        @(negedge clk);
        mem_ready = 0; mem_rdata = 32'h0;
    endtask

    // One full entry sequence; expected values come from the requirements.
    task automatic run_entry(input string tag, input logic undef, input logic trap,
                             input logic slot, input logic [7:0] tv,
                             input logic [31:0] pc, input logic [31:0] sr,
                             input logic [31:0] sp, input logic [7:0] exp_vec,
                             input logic [31:0] exp_ret, input int waits,
                             input logic [31:0] handler, input logic noise);
        instr_valid = 1; instr_undef = undef; instr_trap = trap;
        instr_in_slot = slot; trap_vec = tv;
        cur_pc = pc; cur_sr = sr; cur_sp = sp;
        #0;
        check({tag, " R2 busy on accept"}, {31'b0, busy}, 1);
        @(negedge clk);
        if (noise) begin
            instr_valid = 1; instr_undef = 0; instr_trap = 1; trap_vec = 8'h77;
            cur_sp = 32'h0; cur_sr = 32'h0;
        end else clear_desc();
        serve({tag, " R3 push sr"}, 1, sp - 4, sr, waits, 32'h0);
        serve({tag, " R4 push pc"}, 1, sp - 8, exp_ret, waits, 32'h0);
        clear_desc();
        serve({tag, " R5 R1 vector"}, 0, vec_base + {22'b0, exp_vec, 2'b00}, 32'h0, waits, handler);
        check({tag, " R7 redirect"}, {31'b0, redirect_valid}, 1);
        check({tag, " R10 no req"}, {31'b0, mem_req}, 0);
        check({tag, " R7 target"}, redirect_pc, handler);
        check({tag, " R7 sp"}, new_sp, sp - 8);
        check({tag, " R2 busy at redirect"}, {31'b0, busy}, 1);
        @(negedge clk);
        check({tag, " R7 pulse ends"}, {31'b0, redirect_valid}, 0);
        check({tag, " R2 idle"}, {31'b0, busy}, 0);
    endtask

    task automatic test_reset();
        check("R8 busy", {31'b0, busy}, 0);
        check("R8 req", {31'b0, mem_req}, 0);
        check("R8 redirect", {31'b0, redirect_valid}, 0);
    endtask

    task automatic test_ignored();
        instr_valid = 1; instr_undef = 0; instr_trap = 0; instr_in_slot = 1;
        #0;
        check("R9 no busy", {31'b0, busy}, 0);
        @(negedge clk);
        clear_desc();
        check("R9 no req", {31'b0, mem_req}, 0);
        @(negedge clk);
        check("R9 still idle", {31'b0, busy}, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_desc();
        cur_pc = 0; cur_sr = 0; cur_sp = 0; vec_base = 32'h0000_0400;
        mem_ready = 0; mem_rdata = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        test_reset();
        test_ignored();
        // R1 trap, R4 return address is pc+2
        run_entry("trap", 0, 1, 0, 8'h21, 32'h0000_1000, 32'h0000_00F0,
                  32'h2000_0100, 8'h21, 32'h0000_1002, 0, 32'h0000_8000, 0);
        // R1 slot-illegal, vector 6
        run_entry("slot", 1, 0, 1, 8'h00, 32'h0000_2006, 32'h0000_0001,
                  32'h2000_0200, 8'd6, 32'h0000_2006, 1, 32'h0000_9000, 0);
        // R1 general-illegal, vector 4
        run_entry("gen", 1, 0, 0, 8'h00, 32'h0000_300A, 32'h4000_0003,
                  32'h2000_0080, 8'd4, 32'h0000_300A, 3, 32'h0000_A000, 0);
        // R1 undefined wins over trap; R2 descriptors ignored while busy
        run_entry("prio", 1, 1, 0, 8'h55, 32'h0000_4000, 32'h0000_0010,
                  32'h2000_0400, 8'd4, 32'h0000_4000, 1, 32'h0000_B000, 1);
        // R1 trap with the largest vector number
        run_entry("trapmax", 0, 1, 1, 8'hFF, 32'h0000_5000, 32'h0000_0020,
                  32'h2000_0010, 8'hFF, 32'h0000_5002, 0, 32'h0000_C000, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule